// File: doc/BRIEF.md
# Supply Over-Voltage Fault Mode Controller

This block watches two supply rails for over-voltage and decides how the device's operating mode and regulator enables react. The rail flags are already filtered digital levels. A primary-rail over-voltage can be set up to raise an interrupt only. It can also be set up to shut every regulator off and move the device into fail-safe, or into sleep when fail-safe is disabled. A secondary-rail over-voltage only switches off the secondary regulator and raises its flag.

After a fail-safe entry, the block holds every regulator off for a fixed regulator-off interval, counted in tick pulses. Wake pulses that arrive during this interval are remembered but not acted on. When the interval has passed, the block checks whether the primary fault has gone. If it has, the block leaves fail-safe through a one-cycle restart phase in either of two cases: a wake has been seen, or the primary rail is configured as always-on. A sleep-wake-error timer, started at fail-safe entry, sends the block to sleep when the fault has cleared but no wake ever came.

Top module: `ovfm_ctrl`

## Requirements
- R1: On synchronous reset the mode output is normal (code 0), both regulator enables are 1 and both interrupt flags are 0.
- R2: The mode output codes are normal=0, fail-safe=1, sleep=2, restart=3. In normal mode, with interrupt-only off and fail-safe enabled, an asserted primary flag gives mode fail-safe and both enables 0 one cycle later.
- R3: In normal mode, with interrupt-only off and fail-safe disabled, an asserted primary flag gives mode sleep and both enables 0 one cycle later.
- R4: With interrupt-only on, a primary flag sets interrupt bit 0 only. The mode stays normal and the primary enable stays 1.
- R5: A secondary flag sets interrupt bit 1 and drives the secondary enable to 0 one cycle later, with no mode change.
- R6: In fail-safe, the block cannot leave before REGOFF_TICKS tick pulses have been counted since entry. A wake pulse during that interval is recorded. Once the count is complete and the primary flag is low, the mode becomes restart on the next edge.
- R7: If the primary flag is still high when the regulator-off count completes, the block stays in fail-safe. It goes to restart on the edge after the flag drops, provided a wake was recorded.
- R8: With the fault cleared and the count complete but no wake recorded, the block stays in fail-safe. A later wake pulse moves it to restart on the next edge.
- R9: The sleep-wake-error timer counts tick pulses from fail-safe entry. Once it reaches SWE_TICKS, with the regulator-off count done, the fault cleared and no wake, the mode becomes sleep with both enables 0.
- R10: When the primary rail setting is code 01 (always-on), fail-safe exits to restart once the regulator-off count is complete and the fault is cleared, without any wake.
- R11: Interrupt flags (bit 0 primary, bit 1 secondary) stay set until the matching irq_clr bit is pulsed. If the rail's flag is still high in the clear cycle, the bit stays set.
- R12: Restart sets the primary enable to 1 on entry. Restart lasts one cycle and is followed by normal, where the secondary enable becomes 1 unless the secondary flag is high.
- R13: In sleep, a wake pulse moves the block to restart on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ov_pri | input | 1 | Filtered primary-rail over-voltage flag |
| ov_sec | input | 1 | Filtered secondary-rail over-voltage flag |
| wake_pulse | input | 1 | One-cycle wake event |
| tick | input | 1 | Timer time-base pulse |
| cfg_ov_irq_only | input | 1 | 1: primary over-voltage raises an interrupt only |
| cfg_failsafe_en | input | 1 | 1: primary fault goes to fail-safe, 0: to sleep |
| cfg_pri_mode | input | 2 | Primary rail setting, 01 = always-on |
| irq_clr | input | 2 | Write-one-to-clear pulses for the interrupt flags |
| pri_reg_en | output | 1 | Primary regulator enable |
| sec_reg_en | output | 1 | Secondary regulator enable |
| irq_flags | output | 2 | Sticky flags, bit 0 primary, bit 1 secondary |
| mode | output | 2 | Current mode code |

## Verification
The assertions check the single-cycle rules on every clock. These cover the reaction to a primary fault in each action setting, the secondary shutdown, the regulators being off throughout fail-safe and sleep, restart always handing over to normal, flag stickiness, and the rule that fail-safe is never left while the primary flag is high. The interval rules can only be shown by the bench's scenarios: the exact tick count before exit, a wake remembered across the wait, the sleep-wake-error expiry, and the always-on exit without a wake. For these the bench's reference model tracks the tick counts and the recorded wake, and compares every port on each clock.

// File: rtl/ovfm_pkg.sv
package ovfm_pkg;

    typedef enum logic [1:0] {
        MODE_NORMAL   = 2'd0,
        MODE_FAILSAFE = 2'd1,
        MODE_SLEEP    = 2'd2,
        MODE_RESTART  = 2'd3
    } ovfm_mode_e;

    localparam logic [1:0] PRI_ALWAYS_ON = 2'b01;
    localparam int         NUM_RAILS     = 2;
    localparam int         RAIL_PRI      = 0;
    localparam int         RAIL_SEC      = 1;

    typedef struct packed {
        logic       ov_irq_only;
        logic       failsafe_en;
        logic [1:0] pri_mode;
    } ovfm_cfg_t;

    typedef struct packed {
        logic pri_en;
        logic sec_en;
    } ovfm_regs_t;

    function automatic logic pri_is_always_on(input logic [1:0] code);
        return code == PRI_ALWAYS_ON;
    endfunction

endpackage

// File: rtl/ovfm_tick_timer.sv
module ovfm_tick_timer #(
    parameter int LIMIT = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic tick,
    output logic done
);
    localparam int W = $clog2(LIMIT + 1);
    localparam logic [W-1:0] LIMIT_V = W'(LIMIT);

    logic [W-1:0] count;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            count <= '0;
        end else if (tick && (count != LIMIT_V)) begin
            count <= count + 1'b1;
        end
    end

    assign done = (count == LIMIT_V);
endmodule

// File: rtl/ovfm_irq_flags.sv
module ovfm_irq_flags #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] cond,
    input  logic [N-1:0] clr,
    output logic [N-1:0] flags
);
    for (genvar i = 0; i < N; i++) begin : g_flag
        always_ff @(posedge clk) begin
            if (rst) begin
                flags[i] <= 1'b0;
            end else begin
                flags[i] <= (flags[i] && !clr[i]) || cond[i];
            end
        end
    end
endmodule

// File: rtl/ovfm_mode_fsm.sv
module ovfm_mode_fsm
    import ovfm_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  ovfm_cfg_t  cfg,
    input  logic       ov_pri,
    input  logic       ov_sec,
    input  logic       wake_pulse,
    input  logic       regoff_done,
    input  logic       swe_done,
    output ovfm_mode_e mode,
    output ovfm_regs_t regs,
    output logic       timers_run
);
    logic wake_seen;
    logic fault_gone;
    logic exit_ok;

    assign timers_run = (mode == MODE_FAILSAFE);
    assign fault_gone = regoff_done && !ov_pri;
    assign exit_ok    = fault_gone &&
                        (wake_seen || wake_pulse || pri_is_always_on(cfg.pri_mode));

    always_ff @(posedge clk) begin
        if (rst) begin
            mode        <= MODE_NORMAL;
            regs.pri_en <= 1'b1;
            regs.sec_en <= 1'b1;
            wake_seen   <= 1'b0;
        end else begin
            unique case (mode)
                MODE_NORMAL: begin
                    wake_seen <= 1'b0;
                    if (ov_pri && !cfg.ov_irq_only) begin
                        mode        <= cfg.failsafe_en ? MODE_FAILSAFE : MODE_SLEEP;
                        regs.pri_en <= 1'b0;
                        regs.sec_en <= 1'b0;
                    end else if (ov_sec) begin
                        regs.sec_en <= 1'b0;
                    end
                end
                MODE_FAILSAFE: begin
                    if (exit_ok) begin
                        mode        <= MODE_RESTART;
                        regs.pri_en <= 1'b1;
                        wake_seen   <= 1'b0;
                    end else if (fault_gone && swe_done) begin
                        mode      <= MODE_SLEEP;
                        wake_seen <= 1'b0;
                    end else begin
                        wake_seen <= wake_seen || wake_pulse;
                    end
                end
                MODE_SLEEP: begin
                    wake_seen <= 1'b0;
                    if (wake_pulse) begin
                        mode        <= MODE_RESTART;
                        regs.pri_en <= 1'b1;
                    end
                end
                MODE_RESTART: begin
                    wake_seen   <= 1'b0;
                    mode        <= MODE_NORMAL;
                    regs.sec_en <= !ov_sec;
                end
                default: mode <= MODE_NORMAL;
            endcase
        end
    end
endmodule

// File: rtl/ovfm_ctrl.sv
module ovfm_ctrl
    import ovfm_pkg::*;
#(
    parameter int REGOFF_TICKS = 16,
    parameter int SWE_TICKS    = 64
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       ov_pri,
    input  logic       ov_sec,
    input  logic       wake_pulse,
    input  logic       tick,
    input  logic       cfg_ov_irq_only,
    input  logic       cfg_failsafe_en,
    input  logic [1:0] cfg_pri_mode,
    input  logic [1:0] irq_clr,
    output logic       pri_reg_en,
    output logic       sec_reg_en,
    output logic [1:0] irq_flags,
    output logic [1:0] mode
);
    ovfm_cfg_t  cfg;
    ovfm_regs_t regs;
    ovfm_mode_e mode_q;
    logic       timers_run;
    logic       regoff_done;
    logic       swe_done;
    logic [NUM_RAILS-1:0] ov_vec;

    assign cfg.ov_irq_only = cfg_ov_irq_only;
    assign cfg.failsafe_en = cfg_failsafe_en;
    assign cfg.pri_mode    = cfg_pri_mode;

    assign ov_vec[RAIL_PRI] = ov_pri;
    assign ov_vec[RAIL_SEC] = ov_sec;

    ovfm_tick_timer #(.LIMIT(REGOFF_TICKS)) regoff_tmr_i (
        .clk  (clk),
        .rst  (rst),
        .run  (timers_run),
        .tick (tick),
        .done (regoff_done)
    );

    ovfm_tick_timer #(.LIMIT(SWE_TICKS)) swe_tmr_i (
        .clk  (clk),
        .rst  (rst),
        .run  (timers_run),
        .tick (tick),
        .done (swe_done)
    );

    ovfm_mode_fsm fsm_i (
        .clk         (clk),
        .rst         (rst),
        .cfg         (cfg),
        .ov_pri      (ov_pri),
        .ov_sec      (ov_sec),
        .wake_pulse  (wake_pulse),
        .regoff_done (regoff_done),
        .swe_done    (swe_done),
        .mode        (mode_q),
        .regs        (regs),
        .timers_run  (timers_run)
    );

    ovfm_irq_flags #(.N(NUM_RAILS)) flags_i (
        .clk   (clk),
        .rst   (rst),
        .cond  (ov_vec),
        .clr   (irq_clr),
        .flags (irq_flags)
    );

    assign pri_reg_en = regs.pri_en;
    assign sec_reg_en = regs.sec_en;
    assign mode       = mode_q;
endmodule

// File: rtl/ovfm_ctrl_chk.sv
module ovfm_ctrl_chk
    import ovfm_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       ov_pri,
    input logic       ov_sec,
    input logic       cfg_ov_irq_only,
    input logic       cfg_failsafe_en,
    input logic [1:0] irq_clr,
    input logic       pri_reg_en,
    input logic       sec_reg_en,
    input logic [1:0] irq_flags,
    input logic [1:0] mode
);
    assert_pri_to_failsafe_R2: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_NORMAL && ov_pri && !cfg_ov_irq_only && cfg_failsafe_en)
        |=> (mode == MODE_FAILSAFE && !pri_reg_en && !sec_reg_en));

    assert_pri_to_sleep_R3: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_NORMAL && ov_pri && !cfg_ov_irq_only && !cfg_failsafe_en)
        |=> (mode == MODE_SLEEP && !pri_reg_en && !sec_reg_en));

    assert_irq_only_stays_R4: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_NORMAL && pri_reg_en && ov_pri && cfg_ov_irq_only)
        |=> (mode == MODE_NORMAL && pri_reg_en && irq_flags[0]));

    assert_sec_off_R5: assert property (@(posedge clk) disable iff (rst)
        ov_sec |=> (!sec_reg_en && irq_flags[1]));

    assert_failsafe_regs_off_R2: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_FAILSAFE || mode == MODE_SLEEP) |-> (!pri_reg_en && !sec_reg_en));

    assert_no_exit_with_fault_R7: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_FAILSAFE && ov_pri) |=> (mode == MODE_FAILSAFE));

    assert_flag_sticky_R11: assert property (@(posedge clk) disable iff (rst)
        (irq_flags[0] && !irq_clr[0]) |=> irq_flags[0]);

    assert_restart_to_normal_R12: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_RESTART) |-> (pri_reg_en && !sec_reg_en) ##1 (mode == MODE_NORMAL));
endmodule

bind ovfm_ctrl ovfm_ctrl_chk chk_i (
    .clk             (clk),
    .rst             (rst),
    .ov_pri          (ov_pri),
    .ov_sec          (ov_sec),
    .cfg_ov_irq_only (cfg_ov_irq_only),
    .cfg_failsafe_en (cfg_failsafe_en),
    .irq_clr         (irq_clr),
    .pri_reg_en      (pri_reg_en),
    .sec_reg_en      (sec_reg_en),
    .irq_flags       (irq_flags),
    .mode            (mode)
);

// File: tb/ovfm_ctrl_tb.sv
module ovfm_ctrl_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int T_REGOFF   = 4;
    localparam int T_SWE      = 12;
    localparam int M_NORM = 0, M_FS = 1, M_SLP = 2, M_RST = 3;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ov_pri = 0, ov_sec = 0, wake_pulse = 0, tick = 0;
    logic       cfg_ov_irq_only = 0, cfg_failsafe_en = 1;
    logic [1:0] cfg_pri_mode = 2'b00;
    logic [1:0] irq_clr = 2'b00;
    logic       pri_reg_en, sec_reg_en;
    logic [1:0] irq_flags, mode;

    int    checks = 0;
    int    failures = 0;
    int    cycles = 0;
    string cur_req = "R1";

    // reference model state
    int   m_mode = M_NORM;
    bit   m_pri = 1, m_sec = 1, m_wake = 0;
    bit [1:0] m_flags = 0;
    int   m_roff = 0, m_swe = 0;

    ovfm_ctrl #(.REGOFF_TICKS(T_REGOFF), .SWE_TICKS(T_SWE)) dut_i (
        .clk(clk), .rst(rst), .ov_pri(ov_pri), .ov_sec(ov_sec),
        .wake_pulse(wake_pulse), .tick(tick),
        .cfg_ov_irq_only(cfg_ov_irq_only), .cfg_failsafe_en(cfg_failsafe_en),
        .cfg_pri_mode(cfg_pri_mode), .irq_clr(irq_clr),
        .pri_reg_en(pri_reg_en), .sec_reg_en(sec_reg_en),
        .irq_flags(irq_flags), .mode(mode)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        if (rst) begin
            m_mode = M_NORM; m_pri = 1; m_sec = 1; m_wake = 0;
            m_flags = 0; m_roff = 0; m_swe = 0;
        end else begin
            bit rdone, sdone, clean;
            int nxt;
            m_flags = (m_flags & ~irq_clr) | {ov_sec, ov_pri};
            rdone = (m_roff == T_REGOFF);
            sdone = (m_swe == T_SWE);
            clean = rdone && !ov_pri;
            nxt = m_mode;
            if (m_mode == M_NORM) begin
                if (ov_pri && !cfg_ov_irq_only) begin
                    nxt = cfg_failsafe_en ? M_FS : M_SLP;
                    m_pri = 0; m_sec = 0;
                end else if (ov_sec) m_sec = 0;
            end else if (m_mode == M_FS) begin
                if (clean && (m_wake || wake_pulse || cfg_pri_mode == 2'b01)) begin
                    nxt = M_RST; m_pri = 1;
                end else if (clean && sdone) nxt = M_SLP;
                else begin
                    if (wake_pulse) m_wake = 1;
                    if (tick && !rdone) m_roff++;
                    if (tick && !sdone) m_swe++;
                end
            end else if (m_mode == M_SLP) begin
                if (wake_pulse) begin nxt = M_RST; m_pri = 1; end
            end else begin
                nxt = M_NORM; m_sec = !ov_sec;
            end
            if (nxt != M_FS) begin m_roff = 0; m_swe = 0; m_wake = 0; end
            m_mode = nxt;
        end
    end

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // compare against model each clock, away from the rising edge
    always @(negedge clk) begin
        cycles++;
        if (!rst) begin
            check(cur_req, "model mode", int'(mode), m_mode);
            check(cur_req, "model pri_en", int'(pri_reg_en), int'(m_pri));
            check(cur_req, "model sec_en", int'(sec_reg_en), int'(m_sec));
            check(cur_req, "model flags", int'(irq_flags), int'(m_flags));
        end
    end

    task automatic step(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic clear_all();
        irq_clr = 2'b11; step(1); irq_clr = 2'b00;
    endtask

    // enter fail-safe with a one-cycle primary fault
    task automatic enter_fs(input bit hold);
        ov_pri = 1; step(1);
        if (!hold) ov_pri = 0;
    endtask

    initial begin
        step(3);
        rst = 0;
        step(1);
        check("R1", "reset mode", int'(mode), M_NORM);
        check("R1", "reset enables", int'({pri_reg_en, sec_reg_en}), 3);
        check("R1", "reset flags", int'(irq_flags), 0);

        // interrupt-only action
        cur_req = "R4"; cfg_ov_irq_only = 1;
        ov_pri = 1; step(2); ov_pri = 0; step(1);
        check("R4", "mode kept", int'(mode), M_NORM);
        check("R4", "pri kept on", int'(pri_reg_en), 1);
        check("R4", "flag0 set", int'(irq_flags[0]), 1);
        cur_req = "R11";
        irq_clr = 2'b01; step(1); irq_clr = 0;
        check("R11", "flag0 cleared", int'(irq_flags[0]), 0);
        ov_pri = 1; step(1); irq_clr = 2'b01; step(1); irq_clr = 0; ov_pri = 0;
        check("R11", "flag0 held by live fault", int'(irq_flags[0]), 1);
        clear_all();
        cfg_ov_irq_only = 0;

        // secondary fault
        cur_req = "R5";
        ov_sec = 1; step(1); ov_sec = 0;
        check("R5", "sec off", int'(sec_reg_en), 0);
        check("R5", "mode normal", int'(mode), M_NORM);
        check("R5", "flag1", int'(irq_flags[1]), 1);
        clear_all();

        // fault straight to sleep, wake, restart
        cur_req = "R3"; cfg_failsafe_en = 0;
        enter_fs(0);
        check("R3", "sleep", int'(mode), M_SLP);
        check("R3", "regs off", int'({pri_reg_en, sec_reg_en}), 0);
        cur_req = "R13"; step(3);
        wake_pulse = 1; step(1); wake_pulse = 0;
        check("R13", "restart from sleep", int'(mode), M_RST);
        check("R12", "pri on in restart", int'(pri_reg_en), 1);
        cur_req = "R12"; step(1);
        check("R12", "normal after restart", int'(mode), M_NORM);
        check("R12", "sec back on", int'(sec_reg_en), 1);
        clear_all();

        // fail-safe with wake during regulator-off
        cur_req = "R6"; cfg_failsafe_en = 1; tick = 1;
        enter_fs(0);
        check("R2", "fail-safe entry", int'(mode), M_FS);
        check("R2", "regs off", int'({pri_reg_en, sec_reg_en}), 0);
        wake_pulse = 1; step(1); wake_pulse = 0; step(3);
        check("R6", "still waiting", int'(mode), M_FS);
        step(1);
        check("R6", "restart after interval", int'(mode), M_RST);
        step(1); clear_all();

        // fault held past the interval
        cur_req = "R7";
        enter_fs(1);
        wake_pulse = 1; step(1); wake_pulse = 0; step(7);
        check("R7", "held by fault", int'(mode), M_FS);
        ov_pri = 0; step(1);
        check("R7", "restart after fault clears", int'(mode), M_RST);
        step(1); clear_all();

        // cleared, wake later
        cur_req = "R8";
        enter_fs(0); step(6);
        check("R8", "waiting for wake", int'(mode), M_FS);
        wake_pulse = 1; step(1); wake_pulse = 0;
        check("R8", "restart on wake", int'(mode), M_RST);
        step(1); clear_all();

        // sleep-wake-error expiry
        cur_req = "R9";
        enter_fs(0); step(12);
        check("R9", "before expiry", int'(mode), M_FS);
        step(1);
        check("R9", "sleep after expiry", int'(mode), M_SLP);
        check("R9", "regs off", int'({pri_reg_en, sec_reg_en}), 0);
        wake_pulse = 1; step(1); wake_pulse = 0; step(1); clear_all();

        // always-on rail, no wake
        cur_req = "R10"; cfg_pri_mode = 2'b01;
        enter_fs(0); step(4);
        check("R10", "in interval", int'(mode), M_FS);
        step(1);
        check("R10", "restart without wake", int'(mode), M_RST);
        step(2);
        check("R12", "normal again", int'(mode), M_NORM);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        wait (cycles > 5000);
        failures++;
        $display("FAIL watchdog actual=%0d expected=<5000 cycles", cycles);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule